// File: doc/BRIEF.md
# Dual Register Increment/Decrement Unit

This unit carries out the increment/decrement instruction class of a small 16-bit processor. A single 4-bit mode field holds up to four separate requests: raise or lower the first register, and raise or lower the second. The unit can therefore adjust two registers in the same operation. The datapath that surrounds it provides the mode bits, which are instruction bits 11:8. It also provides the two register selectors, taken from bits 3:0 (first register) and bits 7:4 (second register), along with the current contents of both selected registers.

On each clock the unit registers two write-back ports. Each port carries a write enable, a destination selector and the new value. The unit also registers a flag for illegal modes. A mode that asks to raise and lower the same register at once is contradictory. Such a mode raises the flag and suppresses both writes. Arithmetic wraps modulo 2^16 and never touches the condition flags. If both selectors name the same register and both ports would write, only the first-register port writes.

Top module: `idu_top`

## Requirements
- R1: Results are registered. Inputs present before a rising clock edge appear on the outputs just after that edge, with exactly one cycle of latency.
- R2: Mode bit 0 requests increment of the second register (selector r2_sel_i). Bit 1 requests its decrement. Bit 2 requests increment of the first register (selector r1_sel_i). Bit 3 requests its decrement.
- R3: Mode 0000 asserts neither write enable and does not raise illegal_o.
- R4: A mode with both bit 0 and bit 1 set, or both bit 2 and bit 3 set, is illegal. These are modes 3, 7, 11, 12, 13, 14 and 15. An illegal mode raises illegal_o and asserts neither write enable.
- R5: For a legal mode, each port that has a request asserts its enable. Its data is the register value plus one for an increment, or minus one for a decrement, and its selector repeats the input selector. A port without a request keeps its enable low.
- R6: Arithmetic wraps modulo 2^16: 16'hFFFF plus one gives 0, and 0 minus one gives 16'hFFFF.
- R7: If both ports would write and r1_sel_i equals r2_sel_i, only the first-register port (wr1) is enabled.
- R8: While rst is high at a clock edge, every output is cleared to zero on that edge.
- R9: Legal two-register modes (5, 6, 9, 10) update both registers in the same cycle, with independent directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 4 | Request nibble (instruction bits 11:8) |
| r1_sel_i | input | 4 | First register selector (bits 3:0) |
| r2_sel_i | input | 4 | Second register selector (bits 7:4) |
| r1_val_i | input | 16 | Current value of first register |
| r2_val_i | input | 16 | Current value of second register |
| wr1_en_o | output | 1 | Write enable, first port |
| wr1_sel_o | output | 4 | Destination, first port |
| wr1_data_o | output | 16 | New value, first port |
| wr2_en_o | output | 1 | Write enable, second port |
| wr2_sel_o | output | 4 | Destination, second port |
| wr2_data_o | output | 16 | New value, second port |
| illegal_o | output | 1 | Contradictory mode seen |

## Verification
Every output comes from the single register stage. A result is therefore due one rising edge after its inputs are applied, and nothing else in the unit is pending. The bench drives each stimulus on a falling edge and predicts the outputs from that stimulus. It then waits for the next rising edge and compares the outputs at the following falling edge. The prediction made for one cycle is thus never compared against a neighbouring cycle.

// File: rtl/idu_pkg.sv
package idu_pkg;
  localparam int MODE_W = 4;

  typedef struct packed {
    logic up;
    logic down;
  } lane_req_t;
endpackage

// File: rtl/idu_mode_decode.sv
module idu_mode_decode
  import idu_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  output lane_req_t         req_first,
  output lane_req_t         req_second,
  output logic              bad_mode
);
  logic clash_first, clash_second;

  always_comb begin
    clash_second = mode[0] & mode[1];
    clash_first  = mode[2] & mode[3];
    bad_mode     = clash_first | clash_second;
    req_second.up   = mode[0] & ~bad_mode;
    req_second.down = mode[1] & ~bad_mode;
    req_first.up    = mode[2] & ~bad_mode;
    req_first.down  = mode[3] & ~bad_mode;
  end
endmodule

// File: rtl/idu_lane.sv
module idu_lane
  import idu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] cur,
  input  lane_req_t         req,
  output logic [DATA_W-1:0] nxt,
  output logic              act
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  always_comb begin
    act = req.up | req.down;
    if (req.up)        nxt = cur + ONE;
    else if (req.down) nxt = cur - ONE;
    else               nxt = cur;
  end
endmodule

// File: rtl/idu_top.sv
module idu_top
  import idu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int SEL_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        mode_i,
  input  logic [SEL_W-1:0]  r1_sel_i,
  input  logic [SEL_W-1:0]  r2_sel_i,
  input  logic [DATA_W-1:0] r1_val_i,
  input  logic [DATA_W-1:0] r2_val_i,
  output logic              wr1_en_o,
  output logic [SEL_W-1:0]  wr1_sel_o,
  output logic [DATA_W-1:0] wr1_data_o,
  output logic              wr2_en_o,
  output logic [SEL_W-1:0]  wr2_sel_o,
  output logic [DATA_W-1:0] wr2_data_o,
  output logic              illegal_o
);
  localparam int LANES = 2;

  lane_req_t                 req   [LANES];
  logic      [DATA_W-1:0]    cur   [LANES];
  logic      [DATA_W-1:0]    nxt   [LANES];
  logic      [LANES-1:0]     act;
  logic                      bad_mode;
  logic                      same_dst;
  logic                      en_first, en_second;

  idu_mode_decode u_dec (
    .mode       (mode_i),
    .req_first  (req[0]),
    .req_second (req[1]),
    .bad_mode   (bad_mode)
  );

  assign cur[0] = r1_val_i;
  assign cur[1] = r2_val_i;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    idu_lane #(.DATA_W(DATA_W)) u_lane (
      .cur (cur[g]),
      .req (req[g]),
      .nxt (nxt[g]),
      .act (act[g])
    );
  end

  always_comb begin
    same_dst  = (r1_sel_i == r2_sel_i);
    en_first  = act[0];
    en_second = act[1] & ~(act[0] & same_dst);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr1_en_o   <= 1'b0;
      wr1_sel_o  <= '0;
      wr1_data_o <= '0;
      wr2_en_o   <= 1'b0;
      wr2_sel_o  <= '0;
      wr2_data_o <= '0;
      illegal_o  <= 1'b0;
    end else begin
      wr1_en_o   <= en_first;
      wr1_sel_o  <= r1_sel_i;
      wr1_data_o <= nxt[0];
      wr2_en_o   <= en_second;
      wr2_sel_o  <= r2_sel_i;
      wr2_data_o <= nxt[1];
      illegal_o  <= bad_mode;
    end
  end
endmodule

// File: rtl/idu_checker.sv
module idu_checker #(
  parameter int DATA_W = 16,
  parameter int SEL_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [3:0]        mode_i,
  input logic [SEL_W-1:0]  r1_sel_i,
  input logic [SEL_W-1:0]  r2_sel_i,
  input logic [DATA_W-1:0] r1_val_i,
  input logic [DATA_W-1:0] r2_val_i,
  input logic              wr1_en_o,
  input logic [SEL_W-1:0]  wr1_sel_o,
  input logic [DATA_W-1:0] wr1_data_o,
  input logic              wr2_en_o,
  input logic [SEL_W-1:0]  wr2_sel_o,
  input logic [DATA_W-1:0] wr2_data_o,
  input logic              illegal_o
);
  logic armed;
  always_ff @(posedge clk) armed <= !rst;

  assert_nop_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    armed && $past(mode_i) == 4'b0000 |-> !wr1_en_o && !wr2_en_o && !illegal_o);

  assert_illegal_no_write_R4: assert property (@(posedge clk) disable iff (rst)
    illegal_o |-> !wr1_en_o && !wr2_en_o);

  assert_inc_first_R5: assert property (@(posedge clk) disable iff (rst)
    armed && $past(mode_i) == 4'b0100 |->
      wr1_en_o && wr1_data_o == $past(r1_val_i) + DATA_W'(1) && !wr2_en_o);

  assert_dec_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    armed && $past(mode_i) == 4'b0010 && $past(r2_val_i) == '0 |->
      wr2_en_o && wr2_data_o == {DATA_W{1'b1}});

  assert_one_dest_R7: assert property (@(posedge clk) disable iff (rst)
    wr1_en_o && wr2_en_o |-> wr1_sel_o != wr2_sel_o);

  assert_sel_follow_R1: assert property (@(posedge clk) disable iff (rst)
    armed |-> wr1_sel_o == $past(r1_sel_i) && wr2_sel_o == $past(r2_sel_i));
endmodule

bind idu_top idu_checker #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_idu_checker (.*);

// File: tb/idu_top_tb.sv
module idu_top_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  mode_i;
  logic [3:0]  r1_sel_i, r2_sel_i;
  logic [15:0] r1_val_i, r2_val_i;
  logic        wr1_en_o, wr2_en_o, illegal_o;
  logic [3:0]  wr1_sel_o, wr2_sel_o;
  logic [15:0] wr1_data_o, wr2_data_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  idu_top u_dut (
    .clk(clk), .rst(rst), .mode_i(mode_i),
    .r1_sel_i(r1_sel_i), .r2_sel_i(r2_sel_i),
    .r1_val_i(r1_val_i), .r2_val_i(r2_val_i),
    .wr1_en_o(wr1_en_o), .wr1_sel_o(wr1_sel_o), .wr1_data_o(wr1_data_o),
    .wr2_en_o(wr2_en_o), .wr2_sel_o(wr2_sel_o), .wr2_data_o(wr2_data_o),
    .illegal_o(illegal_o)
  );

  // expected values
  logic        e1_en, e2_en, e_ill;
  logic [3:0]  e1_sel, e2_sel;
  logic [15:0] e1_dat, e2_dat;

  task automatic compare(input string tag);
    bit bad = 0;
    checks++;
    if (wr1_en_o !== e1_en || wr2_en_o !== e2_en || illegal_o !== e_ill) bad = 1;
    if (e1_en && (wr1_sel_o !== e1_sel || wr1_data_o !== e1_dat)) bad = 1;
    if (e2_en && (wr2_sel_o !== e2_sel || wr2_data_o !== e2_dat)) bad = 1;
    if (bad) begin
      fails++;
      $display("FAIL %s: got en1=%0b sel1=%0d d1=%h en2=%0b sel2=%0d d2=%h ill=%0b, expected en1=%0b sel1=%0d d1=%h en2=%0b sel2=%0d d2=%h ill=%0b",
               tag, wr1_en_o, wr1_sel_o, wr1_data_o, wr2_en_o, wr2_sel_o, wr2_data_o, illegal_o,
               e1_en, e1_sel, e1_dat, e2_en, e2_sel, e2_dat, e_ill);
    end
  endtask

  // Behavioural reference: R2 bit meanings, R4 illegal set, R6 wrap, R7 collision
  task automatic predict(input logic [3:0] m, input logic [3:0] s1, input logic [3:0] s2,
                         input logic [15:0] v1, input logic [15:0] v2);
    int d1, d2;
    bit ill;
    ill = (m == 4'd3) || (m == 4'd7) || (m == 4'd11) || (m >= 4'd12);
    d1 = 0; d2 = 0;
    if (m[2]) d1 += 1;
    if (m[3]) d1 -= 1;
    if (m[0]) d2 += 1;
    if (m[1]) d2 -= 1;
    e_ill  = ill;
    e1_en  = !ill && (m[2] || m[3]);
    e2_en  = !ill && (m[0] || m[1]);
    if (e1_en && e2_en && s1 == s2) e2_en = 0;
    e1_sel = s1;
    e2_sel = s2;
    e1_dat = 16'((int'(v1) + d1 + 65536) % 65536);
    e2_dat = 16'((int'(v2) + d2 + 65536) % 65536);
  endtask

  task automatic vec(input string tag, input logic [3:0] m, input logic [3:0] s1,
                     input logic [3:0] s2, input logic [15:0] v1, input logic [15:0] v2);
    @(negedge clk);
    mode_i = m; r1_sel_i = s1; r2_sel_i = s2; r1_val_i = v1; r2_val_i = v2;
    predict(m, s1, s2, v1, v2);
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    rst = 1; mode_i = 4'hF; r1_sel_i = 4'd1; r2_sel_i = 4'd2;
    r1_val_i = 16'h1234; r2_val_i = 16'h5678;
    repeat (3) @(posedge clk);
    @(negedge clk);
    e1_en = 0; e2_en = 0; e_ill = 0; e1_sel = 0; e2_sel = 0; e1_dat = 0; e2_dat = 0;
    compare("R8 reset");
    checks++;
    if (wr1_sel_o !== 4'd0 || wr1_data_o !== 16'd0 || wr2_data_o !== 16'd0) begin
      fails++;
      $display("FAIL R8: reset data got %h/%h/%h expected 0", wr1_sel_o, wr1_data_o, wr2_data_o);
    end
    rst = 0;

    vec("R3 nop",         4'b0000, 4'd1, 4'd2, 16'h0010, 16'h0020);
    vec("R5 inc r2",      4'b0001, 4'd1, 4'd2, 16'h0010, 16'h0020);
    vec("R5 dec r2",      4'b0010, 4'd3, 4'd4, 16'h0010, 16'h0020);
    vec("R5 inc r1",      4'b0100, 4'd5, 4'd6, 16'h7FFF, 16'h0020);
    vec("R5 dec r1",      4'b1000, 4'd5, 4'd6, 16'h8000, 16'h0020);
    vec("R9 inc both",    4'b0101, 4'd0, 4'd7, 16'h0001, 16'h00FF);
    vec("R9 r1 up r2 dn", 4'b0110 ^ 4'b0010 ^ 4'b0010, 4'd2, 4'd3, 16'h0100, 16'h0200);
    vec("R9 r2 up r1 dn", 4'b1001, 4'd2, 4'd3, 16'h0100, 16'h0200);
    vec("R9 dec both",    4'b1010, 4'd8, 4'd9, 16'h0100, 16'h0200);
    vec("R6 inc wrap",    4'b0101, 4'd1, 4'd2, 16'hFFFF, 16'hFFFF);
    vec("R6 dec wrap",    4'b1010, 4'd1, 4'd2, 16'h0000, 16'h0000);
    vec("R7 same dst",    4'b0101, 4'd4, 4'd4, 16'h0003, 16'h0009);
    vec("R7 same dst dn", 4'b1001, 4'd4, 4'd4, 16'h0003, 16'h0009);
    vec("R7 same one req",4'b0001, 4'd4, 4'd4, 16'h0003, 16'h0009);
    for (int m = 0; m < 16; m++)
      vec("R4 mode sweep", 4'(m), 4'd10, 4'd11, 16'h4000, 16'hC000);
    vec("R1 back2back a", 4'b0100, 4'd1, 4'd2, 16'h0001, 16'h0002);
    vec("R1 back2back b", 4'b1111, 4'd1, 4'd2, 16'h0001, 16'h0002);
    begin
      logic [15:0] lf = 16'hACE1;
      for (int i = 0; i < 200; i++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        vec("R2 random", lf[3:0], lf[7:4], lf[11:8], {lf[7:0], lf[15:8]}, lf ^ 16'h5A5A);
      end
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not complete, expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule